// File: doc/BRIEF.md
# Multiplexed LCD Drive Sequencer

This block steps a multiplexed liquid-crystal panel through its common slots and produces, for every common and segment pin, a 2-bit drive-level code that an external analog stage turns into one of four voltages at 1/3 bias. A slow timebase tick sets the pace, and a programmable number of ticks makes up one common slot. With the default of four ticks and a 1 ms tick, a slot lasts 4 ms, so a frame runs at 250/n Hz for n commons. The polarity of every level is inverted on alternate frames so the panel sees no net DC.

Two duty settings are supported. With the duty bit low, three commons are scanned and all 36 segment pins carry pixel data. With it high, segment pin 23 becomes a fourth common and 35 pins remain for pixels. Pixel data sits in a small register file written one nibble at a time over a simple write port. Twelve segment pins, in three groups of four, can each be handed to a plain output latch instead of the panel. Each group has its own select bit.

Top module: `lcd_drive_seq`

## Requirements
- R1: After a synchronous reset, the block is in slot 0 with normal polarity and all pixel data and port latch bits are cleared. Common 0 drives 2'b11, the other commons drive 2'b01 and every segment pin drives 2'b10.
- R2: The level codes are 00 = ground, 01 = 1/3, 10 = 2/3 and 11 = supply. With normal polarity the selected common drives 11 and the unselected commons drive 01. With inverted polarity the selected common drives 00 and the unselected commons drive 10. Exactly one active common is at a rail at any time.
- R3: A segment pin whose pixel bit is set for the current slot drives the rail opposite the selected common: 00 with normal polarity, 11 with inverted polarity. A pin whose bit is clear drives 10 with normal polarity and 01 with inverted polarity.
- R4: The slot advances only on a clock edge with the tick input high, and only after TICKS_PER_SLOT ticks (default 4) have been counted in that slot. Clock edges without a tick have no effect on timing.
- R5: With the duty bit low, commons are selected in the order 0, 1, 2, and the sequence then returns to 0. A frame lasts three slots.
- R6: With the duty bit high, the slots run 0, 1, 2, 3. Segment pin 23 then acts as the fourth common, following the common levels of R2 and selected in slot 3.
- R7: The polarity inverts each time the slot wraps from the last slot back to slot 0.
- R8: A write uses address bits [5:4] as the common row r and bits [3:0] as the nibble index n. For n from 0 to 8, the write loads data bits [3:0] into the pixel bits of segment pins 4n to 4n+3 for row r. The new value appears at the outputs in the cycle after the write edge.
- R9: Port group g (0..2) covers segment pins 24+4g to 27+4g and is loaded by a write to nibble index 9+g, with the row field ignored. While select bit g is high, each pin in the group drives 11 for a latch bit of 1 and 00 for a latch bit of 0, whatever the slot and polarity.
- R10: A change of the duty bit restarts the scan at the next clock edge: slot 0, normal polarity, tick count cleared.
- R11: Writes to nibble indices 12 to 15 change no pixel bit and no port latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Slow timebase pulse, one clock wide |
| duty4 | input | 1 | 0: three commons, 1: four commons |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Row in [5:4], nibble index in [3:0] |
| wr_data | input | 4 | Nibble written |
| port_sel | input | 3 | Per-group hand-over of segment pins to port latches |
| com_drv | output | 6 | Level code of common c in bits [2c+1:2c] |
| seg_drv | output | 72 | Level code of segment pin s in bits [2s+1:2s] |

## Verification
Directed sequences first pin down the reset levels. They then count exactly three ticks and then the fourth, which separates tick-gated slot advance from plain clock counting. They step through full frames in both duty settings to tell correct slot order and polarity inversion apart from a missed wrap or an unswapped rail. Nibble writes into pixel rows, port latches and the unused indices show whether the address decode lands on the right pins. A long random run then mixes sparse ticks, random writes, port-select changes and occasional duty switches, and compares every pin each cycle against a bench model. This exposes interactions such as a duty switch in the middle of a slot or a port hand-over during inverted frames.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    localparam int SLOT_W = 2;

    typedef enum logic [1:0] {
        LV_GND  = 2'b00,
        LV_LOW  = 2'b01,
        LV_HIGH = 2'b10,
        LV_FULL = 2'b11
    } lvl_t;

    typedef struct packed {
        logic              duty4;
        logic              inv;
        logic [SLOT_W-1:0] slot;
    } phase_t;

    // Common pin: selected rides a rail, unselected sits on the near third.
    function automatic lvl_t com_level(input logic sel, input logic inv);
        if (sel) return inv ? LV_GND : LV_FULL;
        return inv ? LV_HIGH : LV_LOW;
    endfunction

    // Segment pin: lit takes the rail opposite the selected common.
    function automatic lvl_t seg_level(input logic lit, input logic inv);
        if (lit) return inv ? LV_FULL : LV_GND;
        return inv ? LV_LOW : LV_HIGH;
    endfunction

    function automatic lvl_t port_level(input logic bit_v);
        return bit_v ? LV_FULL : LV_GND;
    endfunction

endpackage

// File: rtl/lcd_slot_timer.sv
module lcd_slot_timer
    import lcd_seq_pkg::*;
#(
    parameter int TICKS_PER_SLOT = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   duty4,
    output phase_t phase
);
    localparam int CNT_W = (TICKS_PER_SLOT > 1) ? $clog2(TICKS_PER_SLOT) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICKS_PER_SLOT - 1);

    logic [CNT_W-1:0]  cnt_q;
    phase_t            ph_q;
    logic [SLOT_W-1:0] last_slot;

    assign last_slot = ph_q.duty4 ? SLOT_W'(3) : SLOT_W'(2);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ph_q  <= '{duty4: duty4, inv: 1'b0, slot: '0};
        end else if (duty4 != ph_q.duty4) begin
            cnt_q <= '0;
            ph_q  <= '{duty4: duty4, inv: 1'b0, slot: '0};
        end else if (tick) begin
            if (cnt_q == CNT_LAST) begin
                cnt_q <= '0;
                if (ph_q.slot >= last_slot) begin
                    ph_q.slot <= '0;
                    ph_q.inv  <= ~ph_q.inv;
                end else begin
                    ph_q.slot <= ph_q.slot + 1'b1;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign phase = ph_q;

endmodule

// File: rtl/lcd_seg_regfile.sv
module lcd_seg_regfile #(
    parameter int SEG_PINS    = 36,
    parameter int NIB_W       = 4,
    parameter int ROW_W       = 2,
    parameter int IDX_W       = 4,
    parameter int PORT_GROUPS = 3
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                wr_en,
    input  logic [ROW_W+IDX_W-1:0]              wr_addr,
    input  logic [NIB_W-1:0]                    wr_data,
    output logic [(1<<ROW_W)-1:0][SEG_PINS-1:0] seg_rows,
    output logic [PORT_GROUPS*NIB_W-1:0]        port_latch
);
    localparam int NIBBLES = SEG_PINS / NIB_W;
    localparam int IDX_END = NIBBLES + PORT_GROUPS;

    logic [ROW_W-1:0] wr_row;
    logic [IDX_W-1:0] wr_idx;

    assign wr_row = wr_addr[ROW_W+IDX_W-1:IDX_W];
    assign wr_idx = wr_addr[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_rows   <= '0;
            port_latch <= '0;
        end else if (wr_en) begin
            if (wr_idx < IDX_W'(NIBBLES)) begin
                seg_rows[wr_row][wr_idx*NIB_W +: NIB_W] <= wr_data;
            end else if (wr_idx < IDX_W'(IDX_END)) begin
                port_latch[(wr_idx - IDX_W'(NIBBLES))*NIB_W +: NIB_W] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/lcd_pin_mux.sv
module lcd_pin_mux
    import lcd_seq_pkg::*;
#(
    parameter int SEG_PINS    = 36,
    parameter int BASE_COMS   = 3,
    parameter int ROWS        = 4,
    parameter int NIB_W       = 4,
    parameter int SHARED_PIN  = 23,
    parameter int PORT_BASE   = 24,
    parameter int PORT_GROUPS = 3
) (
    input  phase_t                         phase,
    input  logic [ROWS-1:0][SEG_PINS-1:0]  seg_rows,
    input  logic [PORT_GROUPS*NIB_W-1:0]   port_latch,
    input  logic [PORT_GROUPS-1:0]         port_sel,
    output logic [2*BASE_COMS-1:0]         com_drv,
    output logic [2*SEG_PINS-1:0]          seg_drv
);
    localparam int PORT_END = PORT_BASE + PORT_GROUPS * NIB_W;

    logic [SEG_PINS-1:0] cur_row;
    assign cur_row = seg_rows[phase.slot];

    for (genvar c = 0; c < BASE_COMS; c++) begin : g_com
        assign com_drv[2*c +: 2] = com_level(phase.slot == SLOT_W'(c), phase.inv);
    end

    for (genvar s = 0; s < SEG_PINS; s++) begin : g_pin
        if (s >= PORT_BASE && s < PORT_END) begin : g_port
            localparam int GRP = (s - PORT_BASE) / NIB_W;
            localparam int BIT = s - PORT_BASE;
            assign seg_drv[2*s +: 2] = port_sel[GRP] ? port_level(port_latch[BIT])
                                                     : seg_level(cur_row[s], phase.inv);
        end else if (s == SHARED_PIN) begin : g_shared
            assign seg_drv[2*s +: 2] = phase.duty4
                ? com_level(phase.slot == SLOT_W'(BASE_COMS), phase.inv)
                : seg_level(cur_row[s], phase.inv);
        end else begin : g_seg
            assign seg_drv[2*s +: 2] = seg_level(cur_row[s], phase.inv);
        end
    end

endmodule

// File: rtl/lcd_drive_seq.sv
module lcd_drive_seq
    import lcd_seq_pkg::*;
#(
    parameter int SEG_PINS       = 36,
    parameter int BASE_COMS      = 3,
    parameter int TICKS_PER_SLOT = 4,
    parameter int NIB_W          = 4,
    parameter int ROW_W          = 2,
    parameter int IDX_W          = 4,
    parameter int PORT_GROUPS    = 3,
    parameter int SHARED_PIN     = 23,
    parameter int PORT_BASE      = 24
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       tick,
    input  logic                       duty4,
    input  logic                       wr_en,
    input  logic [ROW_W+IDX_W-1:0]     wr_addr,
    input  logic [NIB_W-1:0]           wr_data,
    input  logic [PORT_GROUPS-1:0]     port_sel,
    output logic [2*BASE_COMS-1:0]     com_drv,
    output logic [2*SEG_PINS-1:0]      seg_drv
);
    localparam int ROWS = 1 << ROW_W;

    phase_t                        phase;
    logic [ROWS-1:0][SEG_PINS-1:0] seg_rows;
    logic [PORT_GROUPS*NIB_W-1:0]  port_latch;

    lcd_slot_timer #(
        .TICKS_PER_SLOT(TICKS_PER_SLOT)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .duty4 (duty4),
        .phase (phase)
    );

    lcd_seg_regfile #(
        .SEG_PINS    (SEG_PINS),
        .NIB_W       (NIB_W),
        .ROW_W       (ROW_W),
        .IDX_W       (IDX_W),
        .PORT_GROUPS (PORT_GROUPS)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .seg_rows   (seg_rows),
        .port_latch (port_latch)
    );

    lcd_pin_mux #(
        .SEG_PINS    (SEG_PINS),
        .BASE_COMS   (BASE_COMS),
        .ROWS        (ROWS),
        .NIB_W       (NIB_W),
        .SHARED_PIN  (SHARED_PIN),
        .PORT_BASE   (PORT_BASE),
        .PORT_GROUPS (PORT_GROUPS)
    ) u_mux (
        .phase      (phase),
        .seg_rows   (seg_rows),
        .port_latch (port_latch),
        .port_sel   (port_sel),
        .com_drv    (com_drv),
        .seg_drv    (seg_drv)
    );

endmodule

// File: rtl/lcd_drive_seq_chk.sv
module lcd_drive_seq_chk #(
    parameter int SEG_PINS    = 36,
    parameter int BASE_COMS   = 3,
    parameter int NIB_W       = 4,
    parameter int PORT_GROUPS = 3,
    parameter int SHARED_PIN  = 23,
    parameter int PORT_BASE   = 24
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   tick,
    input logic                   duty4,
    input logic                   wr_en,
    input logic [PORT_GROUPS-1:0] port_sel,
    input logic [2*BASE_COMS-1:0] com_drv,
    input logic [2*SEG_PINS-1:0]  seg_drv
);
    logic                mode4_q;
    logic [BASE_COMS:0]  on_rail;
    logic                sel_full;
    logic                unsel_bad;
    logic                seg_bad;
    logic [SEG_PINS-1:0] port_mask;
    logic [1:0]          shared_code;

    always_ff @(posedge clk) mode4_q <= duty4;

    assign shared_code = seg_drv[2*SHARED_PIN +: 2];

    always_comb begin
        port_mask = '0;
        for (int g = 0; g < PORT_GROUPS; g++)
            for (int b = 0; b < NIB_W; b++)
                port_mask[PORT_BASE + g*NIB_W + b] = port_sel[g];
    end

    always_comb begin
        sel_full = 1'b0;
        for (int c = 0; c < BASE_COMS; c++) begin
            on_rail[c] = (com_drv[2*c +: 2] == 2'b00) || (com_drv[2*c +: 2] == 2'b11);
            if (com_drv[2*c +: 2] == 2'b11) sel_full = 1'b1;
        end
        on_rail[BASE_COMS] = mode4_q && ((shared_code == 2'b00) || (shared_code == 2'b11));
        if (mode4_q && shared_code == 2'b11) sel_full = 1'b1;

        unsel_bad = 1'b0;
        for (int c = 0; c < BASE_COMS; c++)
            if (!on_rail[c] && com_drv[2*c +: 2] != (sel_full ? 2'b01 : 2'b10))
                unsel_bad = 1'b1;
        if (mode4_q && !on_rail[BASE_COMS] && shared_code != (sel_full ? 2'b01 : 2'b10))
            unsel_bad = 1'b1;

        seg_bad = 1'b0;
        for (int s = 0; s < SEG_PINS; s++)
            if (!port_mask[s] && !(mode4_q && s == SHARED_PIN) &&
                seg_drv[2*s +: 2] == (sel_full ? 2'b11 : 2'b00))
                seg_bad = 1'b1;
    end

    assert_single_select_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(on_rail) == 1);

    assert_unselected_level_R2: assert property (@(posedge clk) disable iff (rst)
        !unsel_bad);

    assert_segment_level_R3: assert property (@(posedge clk) disable iff (rst)
        !seg_bad);

    assert_slot_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
        (com_drv != $past(com_drv)) |-> ($past(tick) || ($past(duty4) != $past(duty4, 2))));

    for (genvar g = 0; g < PORT_GROUPS; g++) begin : g_port_chk
        for (genvar b = 0; b < NIB_W; b++) begin : g_bit
            localparam int PIN = PORT_BASE + g*NIB_W + b;
            assert_port_rail_R9: assert property (@(posedge clk) disable iff (rst)
                port_sel[g] |-> (seg_drv[2*PIN +: 2] == 2'b00 || seg_drv[2*PIN +: 2] == 2'b11));
            assert_port_steady_R9: assert property (@(posedge clk) disable iff (rst)
                (port_sel[g] && $past(port_sel[g]) && !$past(wr_en)) |-> $stable(seg_drv[2*PIN +: 2]));
        end
    end

endmodule

bind lcd_drive_seq lcd_drive_seq_chk #(
    .SEG_PINS    (SEG_PINS),
    .BASE_COMS   (BASE_COMS),
    .NIB_W       (NIB_W),
    .PORT_GROUPS (PORT_GROUPS),
    .SHARED_PIN  (SHARED_PIN),
    .PORT_BASE   (PORT_BASE)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .duty4    (duty4),
    .wr_en    (wr_en),
    .port_sel (port_sel),
    .com_drv  (com_drv),
    .seg_drv  (seg_drv)
);

// File: tb/lcd_drive_seq_test.sv
module lcd_drive_seq_test;
    localparam int TPS = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        duty4 = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [3:0]  wr_data = '0;
    logic [2:0]  port_sel = '0;
    logic [5:0]  com_drv;
    logic [71:0] seg_drv;

    always #5 clk = ~clk;

    lcd_drive_seq uut (.*);

    int checks = 0;
    int fails  = 0;

    logic [3:0][35:0] m_rows;
    logic [11:0]      m_latch;
    int               m_slot, m_cnt;
    bit               m_inv, m_duty;

    function automatic logic [1:0] exp_com(bit sel, bit inv);
        if (sel) return inv ? 2'b00 : 2'b11;
        return inv ? 2'b10 : 2'b01;
    endfunction

    function automatic logic [1:0] exp_seg(bit lit, bit inv);
        if (lit) return inv ? 2'b11 : 2'b00;
        return inv ? 2'b01 : 2'b10;
    endfunction

    function automatic logic [5:0] exp_coms();
        logic [5:0] v;
        for (int c = 0; c < 3; c++) v[2*c +: 2] = exp_com(m_slot == c, m_inv);
        return v;
    endfunction

    function automatic logic [71:0] exp_segs();
        logic [71:0] v;
        for (int s = 0; s < 36; s++) begin
            if (s >= 24 && port_sel[(s-24)/4])
                v[2*s +: 2] = m_latch[s-24] ? 2'b11 : 2'b00;
            else if (s == 23 && m_duty)
                v[2*s +: 2] = exp_com(m_slot == 3, m_inv);
            else
                v[2*s +: 2] = exp_seg(m_rows[m_slot][s], m_inv);
        end
        return v;
    endfunction

    task automatic model_edge();
        if (rst) begin
            m_rows = '0; m_latch = '0; m_slot = 0; m_cnt = 0; m_inv = 0; m_duty = duty4;
            return;
        end
        if (wr_en) begin
            if (wr_addr[3:0] < 9)
                m_rows[wr_addr[5:4]][4*wr_addr[3:0] +: 4] = wr_data;
            else if (wr_addr[3:0] < 12)
                m_latch[4*(wr_addr[3:0]-9) +: 4] = wr_data;
        end
        if (duty4 != m_duty) begin
            m_duty = duty4; m_slot = 0; m_cnt = 0; m_inv = 0;
        end else if (tick) begin
            if (m_cnt == TPS-1) begin
                m_cnt = 0;
                if (m_slot == (m_duty ? 3 : 2)) begin m_slot = 0; m_inv = ~m_inv; end
                else m_slot++;
            end else m_cnt++;
        end
    endtask

    task automatic check_vec(string tag, string what, logic [71:0] act, logic [71:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_vec(tag, "commons", {66'd0, com_drv}, {66'd0, exp_coms()});
        check_vec(tag, "segments", seg_drv, exp_segs());
    endtask

    task automatic step(bit t, string tag);
        tick = t;
        cyc(tag);
        tick = 1'b0;
    endtask

    task automatic wr(logic [1:0] row, logic [3:0] idx, logic [3:0] d, string tag);
        wr_en = 1'b1; wr_addr = {row, idx}; wr_data = d;
        cyc(tag);
        wr_en = 1'b0;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL R4 watchdog expired: actual hung expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks + 1);
        $finish;
    end

    initial begin
        logic [71:0] snap;
        void'($urandom(32'd4242));
        repeat (3) cyc("R1");
        rst = 1'b0;
        cyc("R1");
        check_vec("R1", "reset commons", {66'd0, com_drv}, {66'd0, 6'b01_01_11});
        check_vec("R1", "reset segments", seg_drv, {36{2'b10}});

        wr(2'd0, 4'd0, 4'b0011, "R8");
        check_vec("R8", "pins 0..3", {64'd0, seg_drv[7:0]}, {64'd0, 8'b10_10_00_00});

        snap = seg_drv;
        for (int i = 12; i < 16; i++) wr(2'd0, 4'(i), 4'hF, "R11");
        check_vec("R11", "unused index", seg_drv, snap);

        for (int i = 0; i < 3; i++) begin step(1'b1, "R4"); step(1'b0, "R4"); end
        check_vec("R4", "three ticks", {66'd0, com_drv}, {66'd0, 6'b01_01_11});
        step(1'b1, "R4");
        check_vec("R4", "fourth tick", {66'd0, com_drv}, {66'd0, 6'b01_11_01});
        for (int i = 0; i < 4; i++) step(1'b1, "R5");
        check_vec("R5", "slot 2", {66'd0, com_drv}, {66'd0, 6'b11_01_01});
        for (int i = 0; i < 4; i++) step(1'b1, "R7");
        check_vec("R7", "inverted frame", {66'd0, com_drv}, {66'd0, 6'b10_10_00});

        duty4 = 1'b1;
        step(1'b0, "R10");
        check_vec("R10", "restart", {66'd0, com_drv}, {66'd0, 6'b01_01_11});
        check_vec("R10", "pin 23", {70'd0, seg_drv[47:46]}, {70'd0, 2'b01});
        for (int i = 0; i < 12; i++) step(1'b1, "R6");
        check_vec("R6", "slot 3 commons", {66'd0, com_drv}, {66'd0, 6'b01_01_01});
        check_vec("R6", "slot 3 pin 23", {70'd0, seg_drv[47:46]}, {70'd0, 2'b11});
        for (int i = 0; i < 4; i++) step(1'b1, "R7");
        check_vec("R7", "duty4 inversion", {66'd0, com_drv}, {66'd0, 6'b10_10_00});
        check_vec("R7", "duty4 pin 23", {70'd0, seg_drv[47:46]}, {70'd0, 2'b10});

        wr(2'd3, 4'd10, 4'b1001, "R9");
        port_sel = 3'b010;
        step(1'b0, "R9");
        check_vec("R9", "group 1 pins", {64'd0, seg_drv[63:56]}, {64'd0, 8'b11_00_00_11});

        for (int i = 0; i < 5000; i++) begin
            tick = ($urandom_range(0, 2) == 0);
            wr_en = ($urandom_range(0, 3) == 0);
            wr_addr = 6'($urandom_range(0, 63));
            wr_data = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 49) == 0) port_sel = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 299) == 0) duty4 = ~duty4;
            cyc("R3");
        end
        tick = 1'b0; wr_en = 1'b0;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule